// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a load or store instruction and the value that may be written back to the base register. Each cycle it may accept one 32-bit instruction word, the current value of the base register and an offset that the second-operand logic has already produced. It does nothing for words whose major opcode (bits 27:26) is not `01`.

For a memory instruction it picks the offset: either the 12-bit field of the instruction, zero-extended, or the supplied register-based offset. It adds the offset to the base or subtracts it, then chooses the access address. In pre-indexed mode the address is the adjusted base. In post-indexed mode it is the untouched base. The adjusted base is always presented as the writeback value. The writeback enable is raised whenever the base must change. All results are registered and appear one cycle after the instruction, together with a byte/word size select and a load/store direction.

Top module: `ldst_agu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` and `wb_en` are 0.
- R2: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` = 1 and `instr[27:26]` = `01`, and 0 otherwise. When `out_valid` is 0, `wb_en` is 0.
- R3: When `instr[25]` = 0, the offset is `instr[11:0]` zero-extended to 32 bits, and `reg_offset` has no effect on `addr` or `wb_val`.
- R4: When `instr[25]` = 1, the offset is `reg_offset`, and `instr[11:0]` has no effect on `addr` or `wb_val`.
- R5: When `instr[23]` = 1 the adjusted base is base + offset; when it is 0 it is base - offset, both modulo 2^32.
- R6: When `instr[24]` = 1, `addr` is the adjusted base; when it is 0, `addr` is the unmodified `base_val`.
- R7: `wb_val` is always the adjusted base, in pre-indexed and in post-indexed mode.
- R8: `wb_en` is 1 when `instr[24]` = 0, or when `instr[21]` = 1; it is 0 when `instr[24]` = 1 and `instr[21]` = 0.
- R9: `byte_sel` equals `instr[22]` (1 = byte access) and `is_load` equals `instr[20]` (1 = load, 0 = store), registered with the other results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current base register value |
| reg_offset | input | 32 | Register-based offset, already computed |
| out_valid | output | 1 | Registered results belong to a memory instruction |
| addr | output | 32 | Memory access address |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | Value to write back to the base register |
| byte_sel | output | 1 | 1 = byte access, 0 = word access |
| is_load | output | 1 | 1 = load, 0 = store |

## Verification
Every result comes from one register stage, so all of them are due at the first rising edge after the instruction is presented. The driver applies each stimulus on a falling edge and queues the expected results at the same moment. The monitor pops and compares them two nanoseconds after the next rising edge, so it reads settled register outputs and never races the driver. Idle cycles and non-memory words queue an item that expects `out_valid` and `wb_en` low. The no-effect cases put deliberately conflicting values on the unused offset source and check that `addr` and `wb_val` still follow only the selected one.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int INSTR_W   = 32;
    localparam int IMM_W     = 12;

    // Field positions decoded by the datapath
    localparam int OP_HI     = 27;
    localparam int OP_LO     = 26;
    localparam int BIT_REGOF = 25;
    localparam int BIT_PRE   = 24;
    localparam int BIT_ADD   = 23;
    localparam int BIT_BYTE  = 22;
    localparam int BIT_WBQ   = 21;
    localparam int BIT_LOAD  = 20;

    localparam logic [1:0] OP_MEM = 2'b01;

    typedef struct packed {
        logic reg_off;    // offset taken from the register path
        logic pre_index;  // apply offset before the access
        logic add_dir;    // add (1) or subtract (0)
        logic byte_acc;   // byte (1) or word (0)
        logic wb_req;     // explicit writeback request
        logic load_dir;   // load (1) or store (0)
    } mem_ctrl_t;

    function automatic mem_ctrl_t decode_ctrl(input logic [INSTR_W-1:0] iw);
        mem_ctrl_t c;
        c.reg_off   = iw[BIT_REGOF];
        c.pre_index = iw[BIT_PRE];
        c.add_dir   = iw[BIT_ADD];
        c.byte_acc  = iw[BIT_BYTE];
        c.wb_req    = iw[BIT_WBQ];
        c.load_dir  = iw[BIT_LOAD];
        return c;
    endfunction

    function automatic logic is_mem_op(input logic [INSTR_W-1:0] iw);
        return iw[OP_HI:OP_LO] == OP_MEM;
    endfunction

    // Base writeback is needed in post-indexed mode or on request
    function automatic logic needs_wb(input mem_ctrl_t c);
        return !c.pre_index || c.wb_req;
    endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               mem_op,
    output mem_ctrl_t          ctrl,
    output logic [IMM_W-1:0]   imm_field
);
    logic unused_fields;

    always_comb begin
        mem_op    = is_mem_op(instr);
        ctrl      = decode_ctrl(instr);
        imm_field = instr[IMM_W-1:0];
    end

    assign unused_fields = ^{instr[INSTR_W-1:OP_HI+1], instr[BIT_LOAD-1:IMM_W]};

endmodule

// File: rtl/ldst_offset_mux.sv
module ldst_offset_mux #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              reg_sel,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] reg_offset,
    output logic [DATA_W-1:0] offset
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_field};
        end else begin : g_trunc
            assign imm_ext = imm_field[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        offset = reg_sel ? reg_offset : imm_ext;
    end

endmodule

// File: rtl/ldst_addsub.sv
module ldst_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              add_dir,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] operand;

    // Single adder: subtract as base + ~offset + 1
    always_comb begin
        operand = add_dir ? offset : ~offset;
        result  = base + operand + {{(DATA_W-1){1'b0}}, ~add_dir};
    end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] reg_offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] addr,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val,
    output logic              byte_sel,
    output logic              is_load
);
    logic              mem_op;
    mem_ctrl_t         ctrl;
    logic [IMM_W-1:0]  imm_field;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] adj_base;
    logic [DATA_W-1:0] addr_nxt;
    logic              take;

    ldst_decode u_dec (
        .instr     (instr),
        .mem_op    (mem_op),
        .ctrl      (ctrl),
        .imm_field (imm_field)
    );

    ldst_offset_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_off (
        .reg_sel    (ctrl.reg_off),
        .imm_field  (imm_field),
        .reg_offset (reg_offset),
        .offset     (offset)
    );

    ldst_addsub #(.DATA_W(DATA_W)) u_add (
        .base    (base_val),
        .offset  (offset),
        .add_dir (ctrl.add_dir),
        .result  (adj_base)
    );

    always_comb begin
        take     = in_valid && mem_op;
        addr_nxt = ctrl.pre_index ? adj_base : base_val;
    end

    // Valid and enable clear when idle; data fields hold their last value
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            addr      <= '0;
            wb_val    <= '0;
            byte_sel  <= 1'b0;
            is_load   <= 1'b0;
        end else begin
            out_valid <= take;
            wb_en     <= take && needs_wb(ctrl);
            if (take) begin
                addr     <= addr_nxt;
                wb_val   <= adj_base;
                byte_sel <= ctrl.byte_acc;
                is_load  <= ctrl.load_dir;
            end
        end
    end

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] base_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] addr,
    input logic              wb_en,
    input logic [DATA_W-1:0] wb_val,
    input logic              byte_sel,
    input logic              is_load
);
    // R1: reset leaves results idle on the following cycle
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !wb_en));

    // R2: a result appears only after a memory instruction was offered
    p_valid_src_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && instr[27:26] == 2'b01));

    // R2: writeback never fires without a result
    p_wb_gated_r2: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> out_valid);

    // R6: post-indexed accesses use the old base
    p_post_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(instr[24])) |-> addr == $past(base_val));

    // R7: pre-indexed address and writeback value coincide
    p_pre_match_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(instr[24])) |-> addr == wb_val);

    // R8: writeback enable rule
    p_wb_rule_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> wb_en == (!$past(instr[24]) || $past(instr[21])));

    // R9: size and direction follow the instruction
    p_size_dir_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (byte_sel == $past(instr[22]) && is_load == $past(instr[20])));

endmodule

bind ldst_agu ldst_agu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;

    typedef struct {
        logic        vld;
        logic [31:0] addr;
        logic [31:0] wbv;
        logic        wbe;
        logic        bsel;
        logic        ld;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [31:0] base_val;
    logic [31:0] reg_offset;
    logic        out_valid;
    logic [31:0] addr;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        byte_sel;
    logic        is_load;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    bit   done = 0;

    always #5 clk = ~clk;

    ldst_agu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .reg_offset(reg_offset), .out_valid(out_valid),
        .addr(addr), .wb_en(wb_en), .wb_val(wb_val),
        .byte_sel(byte_sel), .is_load(is_load)
    );

    function automatic logic [31:0] mk(input logic [1:0] op, input logic rg,
        input logic p, input logic u, input logic b, input logic w,
        input logic l, input logic [11:0] imm);
        return {4'hE, op, rg, p, u, b, w, l, 8'h35, imm};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue its expected result
    task automatic drive(input logic v, input logic [31:0] iw,
                         input logic [31:0] b, input logic [31:0] ro,
                         input string tag);
        exp_t e;
        logic [31:0] off, adj;
        @(negedge clk);
        in_valid = v; instr = iw; base_val = b; reg_offset = ro;
        off = iw[25] ? ro : {20'd0, iw[11:0]};
        adj = iw[23] ? b + off : b - off;
        e.vld  = v && (iw[27:26] == 2'b01);
        e.addr = iw[24] ? adj : b;
        e.wbv  = adj;
        e.wbe  = e.vld && (!iw[24] || iw[21]);
        e.bsel = iw[22];
        e.ld   = iw[20];
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: results are due one register stage after the drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, "/R2"}, "out_valid", {31'd0, out_valid}, {31'd0, e.vld});
                check({e.tag, "/R8"}, "wb_en", {31'd0, wb_en}, {31'd0, e.wbe});
                if (e.vld) begin
                    check({e.tag, "/R6"}, "addr", addr, e.addr);
                    check({e.tag, "/R7"}, "wb_val", wb_val, e.wbv);
                    check({e.tag, "/R9"}, "byte_sel", {31'd0, byte_sel}, {31'd0, e.bsel});
                    check({e.tag, "/R9"}, "is_load", {31'd0, is_load}, {31'd0, e.ld});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1;
        instr = mk(2'b01, 0, 0, 1, 0, 0, 1, 12'h004);
        base_val = 32'h1000; reg_offset = 32'h0;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs idle during reset even with a valid memory word
        check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1", "wb_en after reset", {31'd0, wb_en}, 32'd0);

        // R3: immediate offset, pre-index add, no writeback; reg_offset is junk
        drive(1, mk(2'b01, 0, 1, 1, 0, 0, 1, 12'hFFF), 32'h0000_2000, 32'hDEAD_BEEF, "R3");
        // R5: pre-index subtract with writeback, byte store
        drive(1, mk(2'b01, 0, 1, 0, 1, 1, 0, 12'h010), 32'h0000_0008, 32'h1234_5678, "R5");
        // R4: register offset; immediate field is junk
        drive(1, mk(2'b01, 1, 1, 1, 0, 1, 1, 12'hABC), 32'h4000_0000, 32'h0000_0100, "R4");
        // R4/R5: register offset subtracted, wraps past zero
        drive(1, mk(2'b01, 1, 1, 0, 0, 0, 0, 12'h777), 32'h0000_0010, 32'h0000_0020, "R4");
        // R6/R8: post-index, W clear still writes back
        drive(1, mk(2'b01, 0, 0, 1, 1, 0, 1, 12'h020), 32'h8000_0000, 32'h0, "R6");
        // R6: post-index subtract with W set
        drive(1, mk(2'b01, 1, 0, 0, 0, 1, 0, 12'h000), 32'h0000_1000, 32'h0000_0004, "R6");
        // R5: add wraps past the top
        drive(1, mk(2'b01, 1, 1, 1, 1, 1, 1, 12'h000), 32'hFFFF_FFF0, 32'h0000_0020, "R5");
        // R2: data-processing and branch words produce nothing
        drive(1, mk(2'b00, 0, 1, 1, 0, 1, 1, 12'h004), 32'h100, 32'h0, "R2");
        drive(1, mk(2'b10, 0, 1, 1, 0, 1, 1, 12'h004), 32'h100, 32'h0, "R2");
        // R2: memory word without in_valid produces nothing
        drive(0, mk(2'b01, 0, 0, 1, 0, 1, 1, 12'h004), 32'h100, 32'h0, "R2");
        // R3: zero immediate, post-index
        drive(1, mk(2'b01, 0, 0, 0, 0, 0, 1, 12'h000), 32'h0000_5555, 32'hFFFF_FFFF, "R3");
        // back-to-back sweep of control patterns
        for (int k = 0; k < 64; k++) begin
            logic [5:0] f;
            f = k[5:0];
            drive(1, mk(2'b01, f[5], f[4], f[3], f[2], f[1], f[0], 12'(k * 37 + 5)),
                  32'h0100_0000 + 32'(k * 4099), 32'(k * 65537 + 3), "R9");
        end
        drive(0, 32'h0, 32'h0, 32'h0, "R2");
        while (sb.size() > 0) @(posedge clk);
        #3;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule